// File: doc/BRIEF.md
# Text Display Timing Chain

This block generates all the raster timing for a 525-line, 59.94 Hz text display running from a clock of about 6.04 MHz. A horizontal counter steps through one scan line per `H_TOTAL` clocks, and a vertical counter steps through the lines of a field. From these two counts it derives a character column index, a text row index and a line-within-row index. It also raises a display-area flag that marks the clocks carrying character dots, and it drives a composite sync waveform with normal, equalizing and broad pulses.

Three text formats are selectable. Two have ten scan lines per row, with 20 or 21 rows. The third has nine scan lines per row and 25 rows. Fields may be interlaced, in which case odd fields carry one extra line, or non-interlaced.

In master mode the block drives composite sync itself. In simple-slave mode the sync pin becomes an input. A falling edge on it re-zeroes the horizontal counter, unless the edge lands within a small dead window around the counter's own wrap point. A pulse held low long enough to be a broad vertical pulse realigns the vertical counter once per field.

Top module: `txt_video_timing`

## Requirements
- R1: While `rst_n` is low, `h_cnt`, `v_cnt`, `field`, `char_col`, `char_row` and `row_line` are 0, `dda` is 0 and `csync_oe` is 1 (with `slave_en` low).
- R2: `h_cnt` counts 0 to `H_TOTAL-1` (default 384) and wraps to 0. `v_cnt` advances by one on each wrap.
- R3: With `interlace_en` low, every field has `V_FIELD` lines (default 262) and `field` reads 0. With it high, `field` toggles at each field wrap, and a field with `field`=1 has `V_FIELD+1` lines.
- R4: A line is horizontally active for `h_cnt` in [`H_ACT_START`, `H_ACT_START+CHARS*DPC`). At `h_cnt = H_ACT_START+k`, `char_col` equals k/`DPC`.
- R5: `dda` is 1 exactly when the line is horizontally active (R4) and `v_cnt` lies in [`V_ACT_START`, `V_ACT_START+N`). N is `ROWS_A*LPR` for `fmt_alt`=0, `rows21`=0; `ROWS_B*LPR` for `fmt_alt`=0, `rows21`=1; and `ROWS_ALT*LPR_ALT` for `fmt_alt`=1 (defaults 20×10, 21×10, 25×9).
- R6: On the active line `V_ACT_START+j`, `row_line` equals j mod L and `char_row` equals j div L, where L is the selected lines per row. After the last active line, both indices hold their final values until the next field's first active line.
- R7: In master mode, `csync_out` is low for `h_cnt < HSYNC_W` on ordinary lines. On lines 0..`EQ_LINES-1` and `2*EQ_LINES`..`3*EQ_LINES-1` it is low for the first `EQ_W` clocks of each half line. On lines `EQ_LINES`..`2*EQ_LINES-1` it is low except for the last `SERR_W` clocks of each half line.
- R8: With `slave_en` high, `csync_oe` is 0. A falling edge on `csync_in` arriving between clock edges makes `h_cnt` read 0 after the second rising edge that follows, provided R9 does not apply.
- R9: If `h_cnt`, read just after the first rising edge following the fall, is at least `H_TOTAL-DEAD` or below `DEAD` (default `DEAD`=2), the edge is ignored and counting continues.
- R10: In slave mode, `csync_in` held low for `VSEP` clocks sets `v_cnt` to `VS_LOAD`. This happens at most once per field; detection re-arms when `v_cnt` reaches `V_ACT_START`.
- R11: With `slave_en` low, `csync_in` has no effect: `h_cnt` and `v_cnt` keep counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | 1 = simple-slave, 0 = master |
| interlace_en | input | 1 | 1 = alternate field lengths |
| fmt_alt | input | 1 | 1 = 25 rows of 9 lines |
| rows21 | input | 1 | With fmt_alt=0: 1 = 21 rows, 0 = 20 rows |
| csync_in | input | 1 | External composite sync (slave mode) |
| csync_out | output | 1 | Generated composite sync, active low |
| csync_oe | output | 1 | Drive enable for the sync pin |
| h_cnt | output | $clog2(H_TOTAL) | Horizontal position |
| v_cnt | output | $clog2(V_FIELD+2) | Line within field |
| field | output | 1 | Current field parity |
| char_col | output | $clog2(CHARS+1) | Character column |
| char_row | output | $clog2(ROWS_A+ROWS_B+ROWS_ALT) | Text row |
| row_line | output | $clog2(LPR+LPR_ALT) | Scan line within text row |
| dda | output | 1 | Display-area flag |

## Verification
The bench shrinks the raster to a 64-clock line and a 50-line field. It keeps 10 and 9 lines per row but uses 2, 3 and 4 rows, six characters of six dots, and a broad-pulse threshold of 12 clocks. With these values, whole fields, both interlaced field lengths and all three formats fit comfortably in the run. Every sync pulse shape can be scanned clock by clock. The dead window can be probed on both sides of the wrap, with the first accepted position next to each rejected one.

// File: rtl/txt_video_timing.sv
module txt_video_timing #(
  parameter int H_TOTAL     = 384,
  parameter int HSYNC_W     = 28,
  parameter int EQ_W        = 13,
  parameter int SERR_W      = 28,
  parameter int H_ACT_START = 96,
  parameter int CHARS       = 40,
  parameter int DPC         = 6,
  parameter int V_FIELD     = 262,
  parameter int V_ACT_START = 21,
  parameter int EQ_LINES    = 3,
  parameter int VS_LOAD     = 3,
  parameter int LPR         = 10,
  parameter int LPR_ALT     = 9,
  parameter int ROWS_A      = 20,
  parameter int ROWS_B      = 21,
  parameter int ROWS_ALT    = 25,
  parameter int DEAD        = 2,
  parameter int VSEP        = 64,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_FIELD + 2),
  localparam int CW = $clog2(CHARS + 1),
  localparam int RW = $clog2(ROWS_A + ROWS_B + ROWS_ALT),
  localparam int LW = $clog2(LPR + LPR_ALT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_en,
  input  logic          interlace_en,
  input  logic          fmt_alt,
  input  logic          rows21,
  input  logic          csync_in,
  output logic          csync_out,
  output logic          csync_oe,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          field,
  output logic [CW-1:0] char_col,
  output logic [RW-1:0] char_row,
  output logic [LW-1:0] row_line,
  output logic          dda
);

  localparam int HALF = H_TOTAL / 2;
  localparam int DW   = $clog2(DPC);
  localparam int SW   = $clog2(VSEP + 1);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_HALF = HW'(HALF);
  localparam logic [HW-1:0] H_A0   = HW'(H_ACT_START);
  localparam logic [HW-1:0] H_A1   = HW'(H_ACT_START + CHARS * DPC);
  localparam logic [HW-1:0] H_A1M  = HW'(H_ACT_START + CHARS * DPC - 1);
  localparam logic [HW-1:0] H_SYNC = HW'(HSYNC_W);
  localparam logic [HW-1:0] H_EQ   = HW'(EQ_W);
  localparam logic [HW-1:0] H_BRD  = HW'(HALF - SERR_W);
  localparam logic [HW-1:0] H_DLO  = HW'(DEAD);
  localparam logic [HW-1:0] H_DHI  = HW'(H_TOTAL - DEAD);

  localparam logic [VW-1:0] V_LAST = VW'(V_FIELD - 1);
  localparam logic [VW-1:0] V_A0   = VW'(V_ACT_START);
  localparam logic [VW-1:0] V_LD   = VW'(VS_LOAD);
  localparam logic [VW-1:0] V_BR0  = VW'(EQ_LINES);
  localparam logic [VW-1:0] V_BR1  = VW'(2 * EQ_LINES);
  localparam logic [VW-1:0] V_EQ1  = VW'(3 * EQ_LINES);
  localparam logic [VW-1:0] N_A    = VW'(ROWS_A * LPR);
  localparam logic [VW-1:0] N_B    = VW'(ROWS_B * LPR);
  localparam logic [VW-1:0] N_C    = VW'(ROWS_ALT * LPR_ALT);

  localparam logic [LW-1:0] LM_STD = LW'(LPR - 1);
  localparam logic [LW-1:0] LM_ALT = LW'(LPR_ALT - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DPC - 1);
  localparam logic [SW-1:0] S_TOP  = SW'(VSEP);
  localparam logic [SW-1:0] S_HIT  = SW'(VSEP - 1);

  logic          s1, s2, arm;
  logic [SW-1:0] low_cnt;
  logic [DW-1:0] dot;
  logic [HW-1:0] h_nxt, hh;
  logic [VW-1:0] v_nxt, v_inc, v_end, v_aend;
  logic [LW-1:0] lpr_m1;
  logic          fall, in_dead, h_rst, h_wrap, v_wrap, sep_hit;
  logic          h_act, v_act, eq_line, broad_line, csync_gen;

  assign fall    = slave_en & s2 & ~s1;
  assign in_dead = (h_cnt >= H_DHI) | (h_cnt < H_DLO);
  assign h_rst   = fall & ~in_dead;
  assign h_wrap  = (h_cnt == H_LAST);
  assign h_nxt   = (h_rst | h_wrap) ? '0 : h_cnt + HW'(1);

  assign sep_hit = slave_en & arm & ~s1 & (low_cnt == S_HIT);
  assign v_end   = V_LAST + VW'(field);
  assign v_wrap  = h_wrap & (v_cnt == v_end);
  assign v_inc   = v_cnt + VW'(1);

  always_comb begin
    if (sep_hit)     v_nxt = V_LD;
    else if (v_wrap) v_nxt = '0;
    else if (h_wrap) v_nxt = v_inc;
    else             v_nxt = v_cnt;
  end

  assign lpr_m1 = fmt_alt ? LM_ALT : LM_STD;
  assign v_aend = V_A0 + (fmt_alt ? N_C : (rows21 ? N_B : N_A));
  assign v_act  = (v_cnt >= V_A0) & (v_cnt < v_aend);
  assign h_act  = (h_cnt >= H_A0) & (h_cnt < H_A1);
  assign dda    = h_act & v_act;

  assign hh         = (h_cnt >= H_HALF) ? h_cnt - H_HALF : h_cnt;
  assign broad_line = (v_cnt >= V_BR0) & (v_cnt < V_BR1);
  assign eq_line    = (v_cnt < V_BR0) | ((v_cnt >= V_BR1) & (v_cnt < V_EQ1));

  always_comb begin
    if (broad_line)   csync_gen = ~(hh < H_BRD);
    else if (eq_line) csync_gen = ~(hh < H_EQ);
    else              csync_gen = ~(h_cnt < H_SYNC);
  end

  assign csync_out = slave_en | csync_gen;
  assign csync_oe  = ~slave_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      low_cnt <= '0;
      arm     <= 1'b1;
    end else begin
      s1 <= csync_in;
      s2 <= s1;
      if (s1)                  low_cnt <= '0;
      else if (low_cnt != S_TOP) low_cnt <= low_cnt + SW'(1);
      if (sep_hit)             arm <= 1'b0;
      else if (v_cnt == V_A0)  arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
      field <= 1'b0;
    end else begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
      if (v_wrap) field <= interlace_en & ~field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot      <= '0;
      char_col <= '0;
    end else if (h_nxt == H_A0) begin
      dot      <= '0;
      char_col <= '0;
    end else if (h_act && !h_rst && h_cnt != H_A1M) begin
      if (dot == D_LAST) begin
        dot      <= '0;
        char_col <= char_col + CW'(1);
      end else begin
        dot <= dot + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_line <= '0;
      char_row <= '0;
    end else if (h_wrap && !sep_hit) begin
      if (v_nxt == V_A0) begin
        row_line <= '0;
        char_row <= '0;
      end else if (v_act && v_inc < v_aend) begin
        if (row_line == lpr_m1) begin
          row_line <= '0;
          char_row <= char_row + RW'(1);
        end else begin
          row_line <= row_line + LW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/txt_video_timing_chk.sv
module txt_video_timing_chk #(
  parameter int H_TOTAL     = 384,
  parameter int V_FIELD     = 262,
  parameter int V_ACT_START = 21,
  parameter int CHARS       = 40,
  parameter int LPR         = 10,
  parameter int LPR_ALT     = 9,
  parameter int ROWS_A      = 20,
  parameter int ROWS_B      = 21,
  parameter int ROWS_ALT    = 25,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_FIELD + 2),
  localparam int CW = $clog2(CHARS + 1),
  localparam int RW = $clog2(ROWS_A + ROWS_B + ROWS_ALT),
  localparam int LW = $clog2(LPR + LPR_ALT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_en,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic [CW-1:0] char_col,
  input logic [RW-1:0] char_row,
  input logic [LW-1:0] row_line,
  input logic          dda
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_PEN  = HW'(H_TOTAL - 2);
  localparam logic [VW-1:0] V_MAX  = VW'(V_FIELD);
  localparam logic [VW-1:0] V_A0   = VW'(V_ACT_START);
  localparam logic [CW-1:0] C_N    = CW'(CHARS);
  localparam logic [LW-1:0] L_MAX  = LW'((LPR > LPR_ALT) ? LPR : LPR_ALT);

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt <= H_LAST); // R2
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt == H_LAST |=> h_cnt == '0); // R2
  AST_MASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && h_cnt != H_LAST) |=> h_cnt == $past(h_cnt) + HW'(1)); // R11
  AST_MASTER_VHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && h_cnt != H_LAST) |=> $stable(v_cnt)); // R11
  AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && h_cnt == '0) |=> h_cnt == HW'(1)); // R9
  AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_en && h_cnt == H_PEN) |=> h_cnt == H_LAST); // R9
  AST_V_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt <= V_MAX); // R3
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dda |-> char_col < C_N); // R4
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dda |-> row_line < L_MAX); // R6
  AST_ROW_START: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt == V_A0 |-> (row_line == '0 && char_row == '0)); // R6
endmodule

bind txt_video_timing txt_video_timing_chk #(
  .H_TOTAL(H_TOTAL), .V_FIELD(V_FIELD), .V_ACT_START(V_ACT_START), .CHARS(CHARS),
  .LPR(LPR), .LPR_ALT(LPR_ALT), .ROWS_A(ROWS_A), .ROWS_B(ROWS_B), .ROWS_ALT(ROWS_ALT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .h_cnt(h_cnt), .v_cnt(v_cnt),
  .char_col(char_col), .char_row(char_row), .row_line(row_line), .dda(dda)
);

// File: tb/sim_txt_video_timing.sv
module sim_txt_video_timing;
  localparam int CLK_T = 10;
  localparam int HT = 64, VF = 50, VA = 10, HA = 12, NCH = 6, DP = 6;
  localparam int RA = 2, RB = 3, RC = 4, LP = 10, LPA = 9, VSP = 12, VLD = 3;

  logic clk = 0, rst_n = 0;
  logic slave_en = 0, interlace_en = 0, fmt_alt = 0, rows21 = 0, csync_in = 1;
  logic csync_out, csync_oe, fld, dda;
  logic [5:0] hc;
  logic [5:0] vc;
  logic [2:0] col;
  logic [3:0] row;
  logic [4:0] lin;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  txt_video_timing #(
    .H_TOTAL(HT), .HSYNC_W(5), .EQ_W(3), .SERR_W(5), .H_ACT_START(HA),
    .CHARS(NCH), .DPC(DP), .V_FIELD(VF), .V_ACT_START(VA), .EQ_LINES(3),
    .VS_LOAD(VLD), .LPR(LP), .LPR_ALT(LPA), .ROWS_A(RA), .ROWS_B(RB),
    .ROWS_ALT(RC), .DEAD(2), .VSEP(VSP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .interlace_en(interlace_en),
    .fmt_alt(fmt_alt), .rows21(rows21), .csync_in(csync_in), .csync_out(csync_out),
    .csync_oe(csync_oe), .h_cnt(hc), .v_cnt(vc), .field(fld), .char_col(col),
    .char_row(row), .row_line(lin), .dda(dda)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_hv(input int h, input int v);
    do @(negedge clk); while (!(hc == h && vc == v));
  endtask

  task automatic wait_h(input int h);
    do @(negedge clk); while (hc != h);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(hc == 0 && vc == 0, "R1 counters", hc + vc, 0);
    chk(row == 0 && lin == 0 && col == 0, "R1 indices", row + lin + col, 0);
    chk(dda == 0, "R1 dda", dda, 0);
    chk(csync_oe == 1, "R1 csync_oe", csync_oe, 1);
    chk(fld == 0, "R1 field", fld, 0);
    rst_n = 1;
  endtask

  task automatic t_hcount;
    wait_hv(HT - 1, 5);
    @(negedge clk);
    chk(hc == 0, "R2 h wrap", hc, 0);
    chk(vc == 6, "R2 v step", vc, 6);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!(hc == 0 && vc == 0));
  endtask

  task automatic t_field;
    int n1, n2, f1, f2;
    wait_hv(0, 0);
    measure(n1);
    chk(n1 == VF * HT, "R3 progressive length", n1, VF * HT);
    chk(fld == 0, "R3 progressive field", fld, 0);
    interlace_en = 1;
    wait_hv(0, 0);
    f1 = fld; measure(n1);
    f2 = fld; measure(n2);
    chk(n1 == (VF + f1) * HT, "R3 interlace field A", n1, (VF + f1) * HT);
    chk(n2 == (VF + f2) * HT, "R3 interlace field B", n2, (VF + f2) * HT);
    chk(f1 != f2, "R3 field toggles", f2, 1 - f1);
    interlace_en = 0;
    wait_hv(0, 0);
    chk(fld == 0, "R3 field cleared", fld, 0);
  endtask

  task automatic t_cols;
    int bad = 0;
    wait_hv(0, VA + 1);
    for (int i = 0; i < HT; i++) begin
      bit act = (i >= HA && i < HA + NCH * DP);
      if (dda != act) bad++;
      if (act && col != (i - HA) / DP) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 column scan", bad, 0);
    bad = 0;
    wait_hv(0, 5);
    for (int i = 0; i < HT; i++) begin
      if (dda) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5 blank line dda", bad, 0);
  endtask

  task automatic t_fmt(input bit fa, input bit r21, input int rows, input int lpr);
    int nact = 0, first = -1, bad = 0, badh = 0;
    wait_hv(0, 0);
    fmt_alt = fa; rows21 = r21;
    for (int v = 0; v < VF; v++) begin
      wait_hv(20, v);
      if (dda) begin
        nact++;
        if (first < 0) first = v;
      end
      if (v >= VA && v < VA + rows * lpr) begin
        if (lin != (v - VA) % lpr || row != (v - VA) / lpr) bad++;
      end else if (v >= VA + rows * lpr) begin
        if (lin != lpr - 1 || row != rows - 1) badh++;
      end
    end
    chk(first == VA, "R5 first active line", first, VA);
    chk(nact == rows * lpr, "R5 active line count", nact, rows * lpr);
    chk(bad == 0, "R6 row and line indices", bad, 0);
    chk(badh == 0, "R6 hold in blanking", badh, 0);
  endtask

  task automatic t_csync;
    int bad;
    bad = 0;
    wait_hv(0, 1);
    for (int i = 0; i < HT; i++) begin
      if (csync_out != !((i % 32) < 3)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 equalizing line", bad, 0);
    bad = 0;
    wait_hv(0, 4);
    for (int i = 0; i < HT; i++) begin
      if (csync_out != !((i % 32) < 27)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 broad line", bad, 0);
    bad = 0;
    wait_hv(0, 20);
    for (int i = 0; i < HT; i++) begin
      if (csync_out != !(i < 5)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 normal line", bad, 0);
  endtask

  task automatic t_master_ignore;
    wait_hv(20, 30);
    csync_in = 0;
    repeat (VSP + 5) @(negedge clk);
    chk(hc == 20 + VSP + 5, "R11 h unaffected", hc, 20 + VSP + 5);
    chk(vc == 30, "R11 v unaffected", vc, 30);
    csync_in = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_at(input int y, input int exp, input string req);
    wait_h(y);
    csync_in = 0;
    @(negedge clk);
    @(negedge clk);
    chk(hc == exp, req, hc, exp);
    csync_in = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave;
    slave_en = 1;
    repeat (4) @(negedge clk);
    chk(csync_oe == 0, "R8 sync pin released", csync_oe, 0);
    pulse_at(20, 0, "R8 edge resets h");
    pulse_at(61, 63, "R9 dead before wrap");
    pulse_at(60, 0, "R9 outside window before wrap");
    pulse_at(0, 2, "R9 dead after wrap");
    pulse_at(1, 0, "R9 outside window after wrap");
  endtask

  task automatic long_low;
    csync_in = 0;
    repeat (VSP + 5) @(negedge clk);
    csync_in = 1;
  endtask

  task automatic t_vsep;
    wait_hv(20, 30);
    long_low();
    chk(vc == VLD, "R10 broad pulse loads line", vc, VLD);
    repeat (4) @(negedge clk);
    wait_hv(20, VLD + 2);
    long_low();
    chk(vc == VLD + 2, "R10 second pulse ignored", vc, VLD + 2);
    repeat (4) @(negedge clk);
    wait_hv(20, 30);
    long_low();
    chk(vc == VLD, "R10 rearmed next field", vc, VLD);
  endtask

  initial begin
    t_reset();
    t_hcount();
    t_field();
    t_cols();
    t_fmt(0, 0, RA, LP);
    t_fmt(0, 1, RB, LP);
    t_fmt(1, 0, RC, LPA);
    t_csync();
    t_master_ignore();
    t_slave();
    t_vsep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++;
      nerr++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule